// File: doc/BRIEF.md
# Two-Agent Priority Bus Arbiter

This block decides which of two agents owns a shared request bus: a symmetric agent on the processor side and a high-priority agent. The symmetric agent asks for the bus on its own active-low request line. The priority agent can claim the bus at any moment through an active-low priority request. That claim stops the symmetric agent from launching new requests, unless those requests belong to a locked (atomic) sequence that is already under way.

Every arbitration input passes through one register stage clocked by the common clock. The block tracks how many requests the priority agent still has in flight, and it flags when the priority request may be withdrawn. It also follows the lock state of the symmetric agent and produces one grant per agent and an issue enable for the symmetric agent.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While rst_ni is low, both grants, the issue enable and the lock flag are 0, the outstanding count is 0 and the release flag is 1.
- R2: With no priority request and no lock, a low sym_req_ni gives sym_gnt_o = 1 after two rising edges: one synchronizer stage and one grant register.
- R3: A low hp_req_ni drops sym_issue_en_o after one rising edge and sets hp_gnt_o (clearing sym_gnt_o) after two, unless a lock is held.
- R4: While lock_o is 1, the symmetric agent keeps its grant and sym_issue_en_o stays 1 even when hp_req_ni is low. sym_issue_en_o is 1 only while sym_gnt_o is 1.
- R5: A sampled sym_issue_i with sym_lock_i = 1 and sym_last_i = 0 sets lock_o. One with sym_lock_i = 1 and sym_last_i = 1 clears it. Issues with sym_lock_i = 0 leave it unchanged. Each change appears two edges after the input is driven.
- R6: hp_outstanding_o rises by one for each sampled hp_issue_i and falls by one for each sampled hp_done_i. It stays put when both occur together. It saturates at 2^CNT_W-1 and at 0 and never wraps.
- R7: hp_release_ok_o is 1 exactly when hp_outstanding_o is 0.
- R8: When both requests arrive together with no lock, the priority agent wins the grant.
- R9: When the priority request is released while the symmetric agent still requests and no lock is held, sym_gnt_o returns two edges later.
- R10: With neither request active and no lock, neither grant is given.
- R11: sym_gnt_o and hp_gnt_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sym_req_ni | input | 1 | Symmetric agent bus request, active low |
| hp_req_ni | input | 1 | Priority agent bus claim, active low |
| hp_issue_i | input | 1 | Priority agent launched a request this cycle |
| hp_done_i | input | 1 | One priority request completed this cycle |
| sym_issue_i | input | 1 | Symmetric agent launched a request this cycle |
| sym_lock_i | input | 1 | That request is part of a locked sequence |
| sym_last_i | input | 1 | That locked request ends the sequence |
| sym_gnt_o | output | 1 | Symmetric agent owns the bus |
| hp_gnt_o | output | 1 | Priority agent owns the bus |
| sym_issue_en_o | output | 1 | Symmetric agent may launch a request |
| lock_o | output | 1 | Locked sequence in progress |
| hp_outstanding_o | output | CNT_W | Priority requests still in flight |
| hp_release_ok_o | output | 1 | Priority claim may be withdrawn |

## Verification
On every cycle the assertions check four things: the two grants never overlap, the issue enable implies the symmetric grant and is never on under a priority grant, a held lock keeps the symmetric grant on the next cycle, and the outstanding count changes by at most one step without wrapping. The delays in cycles, the priority win on simultaneous requests, the handback after release, and the lock being set and cleared in the right order can only be shown by the bench. It runs directed scenarios against its reference model, which steps forward every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_SYM  = 2'd1,
    OWN_HP   = 2'd2
  } owner_e;

  typedef struct packed {
    logic sym_req;
    logic hp_req;
    logic hp_issue;
    logic hp_done;
    logic sym_issue;
    logic sym_lock;
    logic sym_last;
  } arb_in_t;
endpackage

// File: rtl/arb_in_sync.sv
module arb_in_sync
  import arb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  arb_in_t d_i,
  output arb_in_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/arb_hp_ctr.sv
module arb_hp_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end else if (dec_i && !inc_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/arb_lock_trk.sv
module arb_lock_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic lock_i,
  input  logic last_i,
  output logic lock_o
);
  logic lock_q;

  // Lock-tagged issue: first/middle sets, last clears.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lock_q <= 1'b0;
    else if (issue_i && lock_i) lock_q <= !last_i;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sym_req_i,
  input  logic   hp_req_i,
  input  logic   lock_i,
  output owner_e owner_o
);
  owner_e owner_q, owner_d;

  always_comb begin
    if (lock_i)        owner_d = OWN_SYM;  // locked sequence rides through a claim
    else if (hp_req_i) owner_d = OWN_HP;
    else if (sym_req_i) owner_d = OWN_SYM;
    else               owner_d = OWN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_IDLE;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_req_ni,
  input  logic             hp_req_ni,
  input  logic             hp_issue_i,
  input  logic             hp_done_i,
  input  logic             sym_issue_i,
  input  logic             sym_lock_i,
  input  logic             sym_last_i,
  output logic             sym_gnt_o,
  output logic             hp_gnt_o,
  output logic             sym_issue_en_o,
  output logic             lock_o,
  output logic [CNT_W-1:0] hp_outstanding_o,
  output logic             hp_release_ok_o
);
  arb_in_t in_raw, in_q;
  owner_e  owner;
  logic    lock;

  always_comb begin
    in_raw.sym_req   = ~sym_req_ni;
    in_raw.hp_req    = ~hp_req_ni;
    in_raw.hp_issue  = hp_issue_i;
    in_raw.hp_done   = hp_done_i;
    in_raw.sym_issue = sym_issue_i;
    in_raw.sym_lock  = sym_lock_i;
    in_raw.sym_last  = sym_last_i;
  end

  arb_in_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_raw),
    .q_o   (in_q)
  );

  arb_hp_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (in_q.hp_issue),
    .dec_i (in_q.hp_done),
    .cnt_o (hp_outstanding_o),
    .zero_o(hp_release_ok_o)
  );

  arb_lock_trk u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(in_q.sym_issue),
    .lock_i (in_q.sym_lock),
    .last_i (in_q.sym_last),
    .lock_o (lock)
  );

  arb_owner_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sym_req_i(in_q.sym_req),
    .hp_req_i (in_q.hp_req),
    .lock_i   (lock),
    .owner_o  (owner)
  );

  assign sym_gnt_o      = (owner == OWN_SYM);
  assign hp_gnt_o       = (owner == OWN_HP);
  // New symmetric issues stop as soon as a sampled claim is seen, unless locked.
  assign sym_issue_en_o = sym_gnt_o && (!in_q.hp_req || lock);
  assign lock_o         = lock;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sym_gnt_o,
  input logic             hp_gnt_o,
  input logic             sym_issue_en_o,
  input logic             lock_o,
  input logic [CNT_W-1:0] hp_outstanding_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assert_grant_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sym_gnt_o && hp_gnt_o));

  assert_issue_needs_gnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_issue_en_o |-> sym_gnt_o);

  assert_no_issue_under_hp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_gnt_o |-> !sym_issue_en_o);

  assert_lock_keeps_sym_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> sym_gnt_o);

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hp_outstanding_o == $past(hp_outstanding_o)) ||
             (hp_outstanding_o == $past(hp_outstanding_o) + CNT_ONE) ||
             (hp_outstanding_o == $past(hp_outstanding_o) - CNT_ONE));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_outstanding_o == CNT_MAX) |=> (hp_outstanding_o != '0));

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_outstanding_o == '0) |=> (hp_outstanding_o != CNT_MAX));
endmodule

bind prio_bus_arbiter arb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sym_gnt_o       (sym_gnt_o),
  .hp_gnt_o        (hp_gnt_o),
  .sym_issue_en_o  (sym_issue_en_o),
  .lock_o          (lock_o),
  .hp_outstanding_o(hp_outstanding_o)
);

// File: tb/sim_prio_bus_arbiter.sv
`timescale 1ns/1ps
module sim_prio_bus_arbiter;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sym_req_ni = 1'b1, hp_req_ni = 1'b1;
  logic hp_issue_i = 1'b0, hp_done_i = 1'b0;
  logic sym_issue_i = 1'b0, sym_lock_i = 1'b0, sym_last_i = 1'b0;
  logic sym_gnt_o, hp_gnt_o, sym_issue_en_o, lock_o, hp_release_ok_o;
  logic [CNT_W-1:0] hp_outstanding_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  prio_bus_arbiter #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .sym_req_ni(sym_req_ni), .hp_req_ni(hp_req_ni),
    .hp_issue_i(hp_issue_i), .hp_done_i(hp_done_i),
    .sym_issue_i(sym_issue_i), .sym_lock_i(sym_lock_i), .sym_last_i(sym_last_i),
    .sym_gnt_o(sym_gnt_o), .hp_gnt_o(hp_gnt_o), .sym_issue_en_o(sym_issue_en_o),
    .lock_o(lock_o), .hp_outstanding_o(hp_outstanding_o),
    .hp_release_ok_o(hp_release_ok_o)
  );

  // Reference model: sampled inputs, then ownership/lock/count one edge later.
  int s_sreq, s_hreq, s_hiss, s_hdone, s_siss, s_slock, s_slast;
  int m_owner, m_lock, m_cnt;  // owner: 0 none, 1 sym, 2 hp

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s_sreq = 0; s_hreq = 0; s_hiss = 0; s_hdone = 0;
      s_siss = 0; s_slock = 0; s_slast = 0;
      m_owner = 0; m_lock = 0; m_cnt = 0;
    end else begin
      if (m_lock != 0)      m_owner = 1;
      else if (s_hreq != 0) m_owner = 2;
      else if (s_sreq != 0) m_owner = 1;
      else                  m_owner = 0;
      if (s_hiss != 0 && s_hdone == 0 && m_cnt < CMAX) m_cnt++;
      else if (s_hdone != 0 && s_hiss == 0 && m_cnt > 0) m_cnt--;
      if (s_siss != 0 && s_slock != 0) m_lock = (s_slast != 0) ? 0 : 1;
      s_sreq = !sym_req_ni; s_hreq = !hp_req_ni;
      s_hiss = hp_issue_i; s_hdone = hp_done_i;
      s_siss = sym_issue_i; s_slock = sym_lock_i; s_slast = sym_last_i;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_ni) begin
      chk(int'(sym_gnt_o), int'(m_owner == 1), "R2 sym_gnt_o vs model");
      chk(int'(hp_gnt_o), int'(m_owner == 2), "R3 hp_gnt_o vs model");
      chk(int'(sym_issue_en_o),
          int'(m_owner == 1 && (s_hreq == 0 || m_lock != 0)), "R4 sym_issue_en_o vs model");
      chk(int'(lock_o), m_lock, "R5 lock_o vs model");
      chk(int'(hp_outstanding_o), m_cnt, "R6 hp_outstanding_o vs model");
      chk(int'(hp_release_ok_o), int'(m_cnt == 0), "R7 hp_release_ok_o vs model");
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    // R1: reset values
    chk(int'(sym_gnt_o), 0, "R1 sym_gnt_o in reset");
    chk(int'(hp_gnt_o), 0, "R1 hp_gnt_o in reset");
    chk(int'(sym_issue_en_o), 0, "R1 issue_en in reset");
    chk(int'(lock_o), 0, "R1 lock_o in reset");
    chk(int'(hp_outstanding_o), 0, "R1 count in reset");
    chk(int'(hp_release_ok_o), 1, "R1 release_ok in reset");
    rst_ni = 1'b1;

    // R10: idle, no grants
    step(3);
    chk(int'(sym_gnt_o | hp_gnt_o), 0, "R10 no grant when idle");

    // R8: simultaneous requests, priority wins
    sym_req_ni = 1'b0; hp_req_ni = 1'b0;
    step(2);
    chk(int'(hp_gnt_o), 1, "R8 hp wins tie");
    chk(int'(sym_gnt_o), 0, "R8 sym loses tie");

    // Priority agent issues 3, completes 3 (R6/R7)
    hp_issue_i = 1'b1; step(3); hp_issue_i = 1'b0;
    step(2);
    chk(int'(hp_outstanding_o), 3, "R6 three outstanding");
    chk(int'(hp_release_ok_o), 0, "R7 no release with work in flight");
    hp_done_i = 1'b1; step(3); hp_done_i = 1'b0;
    step(2);
    chk(int'(hp_release_ok_o), 1, "R7 release after completions");

    // R9: release claim, symmetric agent regains bus
    hp_req_ni = 1'b1;
    step(2);
    chk(int'(sym_gnt_o), 1, "R9 sym regains bus");
    chk(int'(sym_issue_en_o), 1, "R2 issue enabled");
    sym_issue_i = 1'b1; step(1); sym_issue_i = 1'b0;  // plain issue, lock untouched
    step(2);
    chk(int'(lock_o), 0, "R5 plain issue leaves lock clear");

    // R3: claim while sym owns without lock
    hp_req_ni = 1'b0;
    step(1);
    chk(int'(sym_issue_en_o), 0, "R3 issue blocked after one edge");
    step(1);
    chk(int'(hp_gnt_o), 1, "R3 hp granted after two edges");
    hp_req_ni = 1'b1;
    step(3);

    // R4/R5: locked sequence rides through a claim
    sym_issue_i = 1'b1; sym_lock_i = 1'b1; sym_last_i = 1'b0;
    step(1);
    sym_issue_i = 1'b0; sym_lock_i = 1'b0;
    step(1);
    chk(int'(lock_o), 1, "R5 lock set by first locked issue");
    hp_req_ni = 1'b0;
    step(3);
    chk(int'(sym_gnt_o), 1, "R4 sym keeps bus under claim");
    chk(int'(sym_issue_en_o), 1, "R4 issue stays enabled while locked");
    sym_issue_i = 1'b1; sym_lock_i = 1'b1;
    step(1);  // middle locked issue
    sym_last_i = 1'b1;
    step(1);  // last locked issue
    sym_issue_i = 1'b0; sym_lock_i = 1'b0; sym_last_i = 1'b0;
    step(1);
    chk(int'(lock_o), 0, "R5 lock cleared by last issue");
    step(1);
    chk(int'(hp_gnt_o), 1, "R4 hp takes bus once lock ends");

    // R6: saturation high, simultaneous, saturation low
    hp_issue_i = 1'b1; step(CMAX + 3); hp_issue_i = 1'b0;
    step(2);
    chk(int'(hp_outstanding_o), CMAX, "R6 saturates at max");
    hp_done_i = 1'b1; step(CMAX - 2); hp_done_i = 1'b0;
    step(2);
    chk(int'(hp_outstanding_o), 2, "R6 count down to two");
    hp_issue_i = 1'b1; hp_done_i = 1'b1; step(3);
    hp_issue_i = 1'b0; hp_done_i = 1'b0;
    step(2);
    chk(int'(hp_outstanding_o), 2, "R6 issue and done together hold");
    hp_done_i = 1'b1; step(5); hp_done_i = 1'b0;
    step(2);
    chk(int'(hp_outstanding_o), 0, "R6 saturates at zero");

    hp_req_ni = 1'b1; sym_req_ni = 1'b1;
    step(3);
    chk(int'(sym_gnt_o | hp_gnt_o), 0, "R10 no grant after both release");
    summary();
  end
endmodule